// File: doc/BRIEF.md
# Input Change Interrupt Controller with Per-Pin Capture

This block watches the synchronized levels of a small general-purpose port and produces two values a host can read: the input port byte and an interrupt source byte. It also produces one active-low interrupt line. Each pin keeps a reference level, which is the level the host last saw. A pin set as an input becomes an interrupt source when it differs from that reference.

In the default mode a source goes away again if the pin returns to its reference before anyone reads it. When capture is enabled for a pin, the first change stores the new level and keeps the source alive until a read, so a short pulse is not missed. A per-pin mask gates both the status bits and the interrupt line. All sources clear on the pulse that marks the acknowledge bit of an input-port read.

The block is used behind a register file and a serial bus slave. That surrounding logic supplies the direction, inversion, capture-enable and mask values, and it raises the acknowledge pulse.

Top module: `gpio_chg_irq`

## Requirements
- R1: Bit i of `in_rdata` equals the live pin level XOR `pol_inv[i]` for every pin that holds no captured value, whatever the direction bit says.
- R2: A pin whose `dir_cfg` bit is 0 (output) never becomes an interrupt source, however its level moves.
- R3: A non-capturing input pin is a source in exactly the cycles where its level differs from its reference. Returning to the reference ends the source without a read.
- R4: On a capturing input pin (`latch_en` 1), the first level that differs from the reference is stored. The stored value XOR inversion then appears in `in_rdata`, and the source stays set after the pin returns.
- R5: A cycle with `rd_ack` high clears every stored capture. Each reference then takes the pin level from the cycle before the pulse, and capturing pins show live levels again.
- R6: Clearing `latch_en` while a capture is stored keeps the source pending until `rd_ack`. Meanwhile `in_rdata` shows the live level.
- R7: `stat_rdata` is the source vector ANDed with the inverse of `irq_mask` (1 = masked). Changing the mask affects `stat_rdata` and `int_n` in the same cycle.
- R8: `int_n` is low exactly when `stat_rdata` is non-zero, and high otherwise.
- R9: Turning an output pin into an input while its level differs from its reference makes it a source at once.
- R10: A pin change that lands in the same cycle as `rd_ack` is not lost. The reference takes the older level, so the pin is a source after the pulse.
- R11: During synchronous reset (`rst_n` low), every reference is loaded with the pin levels and every capture is cleared. After release, no source exists and `int_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | PINS | Synchronized pin levels |
| dir_cfg | input | PINS | Direction per pin, 1 = input |
| pol_inv | input | PINS | Read inversion per pin, 1 = inverted |
| latch_en | input | PINS | Capture enable per pin |
| irq_mask | input | PINS | Interrupt mask per pin, 1 = masked |
| rd_ack | input | 1 | One-cycle pulse at the acknowledge of an input-port read |
| in_rdata | output | PINS | Input port read value |
| stat_rdata | output | PINS | Unmasked interrupt source bits |
| int_n | output | 1 | Active-low interrupt, low while any status bit is set |

## Verification
The bench builds the block with its default of eight pins. That is a full byte, so one run can give pins different directions, inversions, capture settings and mask bits at the same time. At that width, every pin pattern in the random phase can also be compared against the reference model byte-wide on each clock. The directed part places a capture, its release by `rd_ack`, and a change on the acknowledge cycle on chosen bits, while the neighbouring bits carry other settings. This exposes any crosstalk between pin cells.

// File: rtl/gpio_chg_pkg.sv
// Package: shared defaults and the per-pin result record.
// Assumes: nothing; compiled first.
package gpio_chg_pkg;

    parameter int unsigned PIN_COUNT_DEF = 8;

    typedef struct packed {
        logic src;      // pin is a current interrupt source
        logic rd_bit;   // bit presented in the input port read value
    } pin_res_t;

endpackage

// File: rtl/gpio_chg_cell.sv
// Module: one pin's change detector.
// It keeps the reference level (the level the host last read), an optional
// captured level, and it forms the read bit and the source flag.
// Assumes: pin is already synchronized; rd_ack is a one-cycle pulse.
module gpio_chg_cell
    import gpio_chg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin,
    input  logic     dir_in,
    input  logic     pol,
    input  logic     lat_en,
    input  logic     rd_ack,
    output pin_res_t res
);

    logic ref_q;
    logic pin_q;
    logic hold_q;
    logic cap_q;
    logic diff;

    assign diff = pin ^ ref_q;

    // Purpose: reference tracks the last read level; pin_q is the prior-cycle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= pin;
            pin_q <= pin;
        end else begin
            pin_q <= pin;
            if (rd_ack) begin
                ref_q <= pin_q;
            end
        end
    end

    // Purpose: store the first differing level of a capturing input until read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            cap_q  <= 1'b0;
        end else if (rd_ack) begin
            hold_q <= 1'b0;
        end else if (dir_in && lat_en && !hold_q && diff) begin
            hold_q <= 1'b1;
            cap_q  <= pin;
        end
    end

    // Purpose: present the read bit and the source flag.
    always_comb begin
        res.src    = hold_q | (dir_in & diff);
        res.rd_bit = ((hold_q & lat_en) ? cap_q : pin) ^ pol;
    end

    // R4: a stored capture survives until the read acknowledge
    p_hold_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !rd_ack) |=> hold_q);

    // R4: the stored level does not move while held
    p_cap_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !rd_ack) |=> $stable(cap_q));

    // R5: the acknowledge drops any stored capture
    p_ack_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !hold_q);

    // R2: an output pin never starts a capture
    p_out_nohold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_in && !hold_q) |=> !hold_q);

endmodule

// File: rtl/gpio_chg_merge.sv
// Module: applies the mask to the source vector and forms the interrupt line.
// Assumes: irq_mask bit 1 means masked; the line is active low.
module gpio_chg_merge #(
    parameter int unsigned PINS = 8
) (
    input  logic [PINS-1:0] src,
    input  logic [PINS-1:0] irq_mask,
    output logic [PINS-1:0] stat,
    output logic            int_n
);

    // Purpose: gate sources by the mask and drive the line low on any survivor.
    always_comb begin
        stat  = src & ~irq_mask;
        int_n = ~(|stat);
    end

endmodule

// File: rtl/gpio_chg_irq.sv
// Module: top of the input change interrupt controller.
// It builds one detector per pin and merges their sources through the mask.
// Assumes: all configuration inputs come from registers clocked by clk.
module gpio_chg_irq
    import gpio_chg_pkg::*;
#(
    parameter int unsigned PINS = PIN_COUNT_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_lvl,
    input  logic [PINS-1:0] dir_cfg,
    input  logic [PINS-1:0] pol_inv,
    input  logic [PINS-1:0] latch_en,
    input  logic [PINS-1:0] irq_mask,
    input  logic            rd_ack,
    output logic [PINS-1:0] in_rdata,
    output logic [PINS-1:0] stat_rdata,
    output logic            int_n
);

    pin_res_t        res [PINS];
    logic [PINS-1:0] src;

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        gpio_chg_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (pin_lvl[g]),
            .dir_in (dir_cfg[g]),
            .pol    (pol_inv[g]),
            .lat_en (latch_en[g]),
            .rd_ack (rd_ack),
            .res    (res[g])
        );
        assign src[g]      = res[g].src;
        assign in_rdata[g] = res[g].rd_bit;
    end

    gpio_chg_merge #(.PINS(PINS)) u_merge (
        .src      (src),
        .irq_mask (irq_mask),
        .stat     (stat_rdata),
        .int_n    (int_n)
    );

    // Purpose: tie the merged outputs to each other and to the mask.
    always_comb begin
        if (rst_n) begin
            // R8: line low exactly when some status bit is set
            p_int_status_r8: assert (int_n == (stat_rdata == '0));
            // R7: a masked pin never shows in status
            p_stat_masked_r7: assert ((stat_rdata & irq_mask) == '0);
        end
    end

endmodule

// File: tb/gpio_chg_irq_tb_top.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module gpio_chg_irq_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] pin_lvl, dir_cfg, pol_inv, latch_en, irq_mask;
    logic         rd_ack;
    logic [W-1:0] in_rdata, stat_rdata;
    logic         int_n;

    int n_chk = 0;
    int n_bad = 0;
    bit model_ok = 0;
    bit done = 0;

    // model state
    logic [W-1:0] m_ref, m_hold, m_cap, m_pinq;

    always #10 clk = ~clk;

    gpio_chg_irq #(.PINS(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .dir_cfg(dir_cfg),
        .pol_inv(pol_inv), .latch_en(latch_en), .irq_mask(irq_mask),
        .rd_ack(rd_ack), .in_rdata(in_rdata), .stat_rdata(stat_rdata),
        .int_n(int_n)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // model update at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ref  = pin_lvl;
            m_pinq = pin_lvl;
            m_hold = '0;
            m_cap  = '0;
            model_ok = 1;
        end else begin
            for (int i = 0; i < W; i++) begin
                if (rd_ack) m_hold[i] = 1'b0;
                else if (dir_cfg[i] && latch_en[i] && !m_hold[i] && (pin_lvl[i] != m_ref[i])) begin
                    m_hold[i] = 1'b1;
                    m_cap[i]  = pin_lvl[i];
                end
            end
            if (rd_ack) m_ref = m_pinq;
            m_pinq = pin_lvl;
        end
    end

    // compare against the model away from the edge
    always @(negedge clk) begin
        logic [W-1:0] e_src, e_stat, e_rd;
        #2;
        if (model_ok && rst_n && !done) begin
            for (int i = 0; i < W; i++) begin
                e_src[i] = m_hold[i] || (dir_cfg[i] && (pin_lvl[i] != m_ref[i]));
                e_rd[i]  = ((m_hold[i] && latch_en[i]) ? m_cap[i] : pin_lvl[i]) ^ pol_inv[i];
            end
            e_stat = e_src & ~irq_mask;
            chk("R1 model rdata", in_rdata, e_rd);
            chk("R7 model status", stat_rdata, e_stat);
            chk("R8 model int_n", {7'd0, int_n}, {7'd0, (e_stat == '0)});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic look;
        #2;
    endtask

    initial begin
        rst_n = 0; pin_lvl = 8'h00; dir_cfg = 8'hFF; pol_inv = 8'h00;
        latch_en = 8'h00; irq_mask = 8'hFF; rd_ack = 0;
        cyc(3);
        rst_n = 1;
        cyc(1); look;
        chk("R11 int_n after reset", {7'd0, int_n}, 8'h01);
        chk("R11 status after reset", stat_rdata, 8'h00);
        chk("R11 rdata after reset", in_rdata, 8'h00);

        irq_mask = 8'h00;
        cyc(1); pin_lvl = 8'h01; look;
        chk("R3 source on change", stat_rdata, 8'h01);
        chk("R8 int low", {7'd0, int_n}, 8'h00);
        cyc(1); pin_lvl = 8'h00; look;
        chk("R3 source gone on return", stat_rdata, 8'h00);

        cyc(1); dir_cfg = 8'h00; pol_inv = 8'hF0; pin_lvl = 8'h3C; look;
        chk("R1 rdata on outputs", in_rdata, 8'hCC);
        chk("R2 no source from outputs", stat_rdata, 8'h00);
        cyc(1); dir_cfg = 8'hFF; look;
        chk("R9 output to input raises", stat_rdata, 8'h3C);

        cyc(1); rd_ack = 1;
        cyc(1); rd_ack = 0; look;
        chk("R5 ack clears", stat_rdata, 8'h00);

        cyc(1); pol_inv = 8'h00; latch_en = 8'hFF; pin_lvl = 8'h3E;
        cyc(1); pin_lvl = 8'h3C; look;
        chk("R4 captured value shown", in_rdata, 8'h3E);
        chk("R4 source held", stat_rdata, 8'h02);
        cyc(1); rd_ack = 1;
        cyc(1); rd_ack = 0; look;
        chk("R5 live after ack", in_rdata, 8'h3C);
        chk("R5 source cleared", stat_rdata, 8'h00);

        cyc(1); pin_lvl = 8'h3D;
        cyc(1); latch_en = 8'h00; pin_lvl = 8'h3C; look;
        chk("R6 pending kept", stat_rdata, 8'h01);
        chk("R6 live level read", in_rdata, 8'h3C);
        cyc(1); rd_ack = 1;
        cyc(1); rd_ack = 0;

        cyc(1); irq_mask = 8'h01; pin_lvl = 8'h3D; look;
        chk("R7 masked status", stat_rdata, 8'h00);
        chk("R7 masked int", {7'd0, int_n}, 8'h01);
        cyc(1); irq_mask = 8'h00; look;
        chk("R7 unmask asserts", {7'd0, int_n}, 8'h00);
        cyc(1); irq_mask = 8'h01; look;
        chk("R7 remask releases", {7'd0, int_n}, 8'h01);
        cyc(1); irq_mask = 8'h00; pin_lvl = 8'h3C;
        cyc(1);

        rd_ack = 1; pin_lvl = 8'h3D;
        cyc(1); rd_ack = 0; look;
        chk("R10 change on ack kept", stat_rdata, 8'h01);
        cyc(1); rd_ack = 1;
        cyc(1); rd_ack = 0;

        for (int k = 0; k < 2000; k++) begin
            cyc(1);
            if ($urandom_range(3) == 0) pin_lvl = pin_lvl ^ (8'h01 << $urandom_range(7));
            if ($urandom_range(15) == 0) dir_cfg = 8'($urandom);
            if ($urandom_range(15) == 0) latch_en = 8'($urandom);
            if ($urandom_range(15) == 0) pol_inv = 8'($urandom);
            if ($urandom_range(15) == 0) irq_mask = 8'($urandom);
            rd_ack = ($urandom_range(9) == 0);
        end
        cyc(1); rd_ack = 0;
        cyc(2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule